// File: doc/BRIEF.md
# Sense-Selectable Interrupt Conditioner

The block takes one asynchronous interrupt request wire and turns it into a single active-high level request for a parent interrupt controller. Software chooses what counts as an event: the wire held low, the wire held high, a falling transition or a rising transition. A detected event latches a pending flag. Software clears the flag by writing a one to it, and a separate enable bit decides whether the latched request reaches the parent.

The raw wire is first resynchronised by a chain of flops. A detector compares the synchronised sample with the sample from the previous cycle, and a two-state machine holds the pending flag. Its states are `PEND_IDLE` and `PEND_ACTIVE`. The machine moves from `PEND_IDLE` to `PEND_ACTIVE` on any detected event (transition *raise*). It moves from `PEND_ACTIVE` back to `PEND_IDLE` on an acknowledge write in a cycle with no event (transition *clear*). It stays in `PEND_ACTIVE` if an event arrives, or if no acknowledge is written (transition *hold*). It stays in `PEND_IDLE` while there is no event (transition *rest*). The registers sit on a plain 32-bit read/write port. One of two address layouts is fixed at elaboration time.

Top module: `irq_sense_ctrl`

## Requirements
- R1: Bits [1:0] of the control register hold the sense mode: 0 = input low is active, 1 = falling transition, 2 = input high is active, 3 = rising transition. A control write stores only bits [1:0], and a read returns the mode in bits [1:0] with zero in bits [31:2].
- R2: The input passes through a two-flop synchroniser. A change on `irq_in` set up before clock edge k shows up as an event when the detector evaluates at edge k+2, and the pending flag is set at that edge.
- R3: In the two transition modes the pending flag is set on the selected transition of the synchronised input. It then stays set, whatever the input does, until it is acknowledged.
- R4: In the two level modes, if the input is still at its active level after an acknowledge, the pending flag is set again on the next clock edge.
- R5: A write to the pending register with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves the flag unchanged.
- R6: When an acknowledge write and a detected event fall on the same clock edge, the flag stays set.
- R7: Bit 0 of the enable register gates the request. `irq_out` is a registered copy of (pending AND enable), so it follows either input one clock edge later.
- R8: After reset the mode is 0 (input low is active), the enable bit is 0, the pending flag is clear and `irq_out` is 0.
- R9: With `LAYOUT` = 0 the control, pending and enable registers are at byte offsets 0x00, 0x04 and 0x08. With `LAYOUT` = 1 they are at 0x0C, 0x10 and 0x40. A write to any other address changes nothing, and a read from any other address returns zero.
- R10: A read of the pending register returns the flag in bit 0, and a read of the enable register returns the enable bit in bit 0. All other bits of both read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | Raw asynchronous interrupt request wire |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| irq_out | output | 1 | Active-high level request to the parent controller |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are synchronous to `clk` and stable around the rising edge. They also assume that `irq_in` may change at any time, because the synchroniser absorbs it. The stimulus keeps to this by changing every input one nanosecond after a falling edge. It drives the same sequence into a `LAYOUT` = 0 instance and a `LAYOUT` = 1 instance, each with that layout's addresses, plus an address that is unmapped in both. A behavioural model predicts `irq_out` and the selected read value for every cycle, covering directed mode, acknowledge and collision cases and a random stretch.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    // Encoding of the two-bit sense field; the values are software-visible.
    typedef enum logic [1:0] {
        SENSE_LEVEL_LOW  = 2'd0,
        SENSE_EDGE_FALL  = 2'd1,
        SENSE_LEVEL_HIGH = 2'd2,
        SENSE_EDGE_RISE  = 2'd3
    } sense_mode_e;

    typedef enum logic {
        PEND_IDLE   = 1'b0,
        PEND_ACTIVE = 1'b1
    } pend_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else if (g == 0) begin
                    chain_q[g] <= d_async;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect
    import irq_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sample,
    input  sense_mode_e mode,
    output logic        evt
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sample;
    end

    always_comb begin
        unique case (mode)
            SENSE_LEVEL_LOW:  evt = ~sample;
            SENSE_EDGE_FALL:  evt = prev_q & ~sample;
            SENSE_LEVEL_HIGH: evt = sample;
            SENSE_EDGE_RISE:  evt = ~prev_q & sample;
            default:          evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_pend_fsm.sv
module irq_pend_fsm
    import irq_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack,
    input  logic en,
    output logic pend,
    output logic irq_q
);
    pend_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PEND_IDLE;
        else        state_q <= state_d;
    end

    // Next state: raise, clear, hold, rest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE:   if (evt) state_d = PEND_ACTIVE;
            PEND_ACTIVE: if (ack && !evt) state_d = PEND_IDLE;
            default:     state_d = PEND_IDLE;
        endcase
    end

    // Outputs: flag is the state, request is registered and gated
    assign pend = (state_q == PEND_ACTIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend & en;
    end
endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
    import irq_sense_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LAYOUT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pend,
    output logic [DATA_W-1:0] rdata,
    output sense_mode_e       mode,
    output logic              en,
    output logic              ack
);
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'((LAYOUT == 0) ? 'h00 : 'h0C);
    localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'((LAYOUT == 0) ? 'h04 : 'h10);
    localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'((LAYOUT == 0) ? 'h08 : 'h40);

    logic hit_ctrl, hit_pend, hit_en;

    assign hit_ctrl = (addr == OFF_CTRL);
    assign hit_pend = (addr == OFF_PEND);
    assign hit_en   = (addr == OFF_EN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= SENSE_LEVEL_LOW;
            en   <= 1'b0;
        end else if (wr_en) begin
            if (hit_ctrl) mode <= sense_mode_e'(wdata[1:0]);
            if (hit_en)   en   <= wdata[0];
        end
    end

    assign ack = wr_en & hit_pend & wdata[0];

    always_comb begin
        rdata = '0;
        if (hit_ctrl)      rdata[1:0] = mode;
        else if (hit_pend) rdata[0]   = pend;
        else if (hit_en)   rdata[0]   = en;
    end
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
    import irq_sense_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int LAYOUT      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);
    logic        sample;
    logic        evt;
    logic        ack;
    logic        en;
    logic        pend;
    sense_mode_e mode;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_in),
        .q_sync  (sample)
    );

    irq_event_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .mode   (mode),
        .evt    (evt)
    );

    irq_sense_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .pend  (pend),
        .rdata (rdata),
        .mode  (mode),
        .en    (en),
        .ack   (ack)
    );

    irq_pend_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .ack   (ack),
        .en    (en),
        .pend  (pend),
        .irq_q (irq_out)
    );
endmodule

// File: rtl/irq_sense_checker.sv
module irq_sense_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt,
    input logic              ack,
    input logic              en,
    input logic              pend,
    input logic              irq_out,
    input logic [DATA_W-1:0] rdata
);
    AST_EVT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ack && !evt) |=> !pend); // R5

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && evt) |=> pend); // R6

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(pend && en)); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !evt) |=> !pend); // R4

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:2] == '0); // R10
endmodule

bind irq_sense_ctrl irq_sense_checker #(.DATA_W(DATA_W)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .ack     (ack),
    .en      (en),
    .pend    (pend),
    .irq_out (irq_out),
    .rdata   (rdata)
);

// File: tb/irq_sense_ctrl_bench.sv
`timescale 1ns/1ps
module irq_sense_ctrl_bench;
    localparam int IDX_CTRL = 0, IDX_PEND = 1, IDX_EN = 2, IDX_NONE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_in = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    int          idx = IDX_CTRL;
    logic [7:0]  addr_a, addr_b;
    logic [31:0] rdata_a, rdata_b;
    logic        out_a, out_b;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string phase = "R8 reset";

    // model state
    int m_s1 = 0, m_s2 = 0, m_prev = 0, m_mode = 0, m_en = 0, m_pend = 0, m_out = 0;

    always #10 clk = ~clk;

    always_comb begin
        case (idx)
            IDX_CTRL: begin addr_a = 8'h00; addr_b = 8'h0C; end
            IDX_PEND: begin addr_a = 8'h04; addr_b = 8'h10; end
            IDX_EN:   begin addr_a = 8'h08; addr_b = 8'h40; end
            default:  begin addr_a = 8'h20; addr_b = 8'h20; end
        endcase
    end

    irq_sense_ctrl #(.LAYOUT(0)) u_irq_sense_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr_a), .wdata(wdata), .rdata(rdata_a), .irq_out(out_a));

    irq_sense_ctrl #(.LAYOUT(1)) u_irq_sense_ctrl_b (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr_b), .wdata(wdata), .rdata(rdata_b), .irq_out(out_b));

    function automatic int model_evt();
        case (m_mode)
            0: return (m_s2 == 0) ? 1 : 0;
            1: return (m_prev == 1 && m_s2 == 0) ? 1 : 0;
            2: return (m_s2 == 1) ? 1 : 0;
            default: return (m_prev == 0 && m_s2 == 1) ? 1 : 0;
        endcase
    endfunction

    function automatic logic [31:0] model_rd();
        case (idx)
            IDX_CTRL: return 32'(m_mode);
            IDX_PEND: return 32'(m_pend);
            IDX_EN:   return 32'(m_en);
            default:  return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_mode = 0; m_en = 0; m_pend = 0; m_out = 0;
        end else begin
            int ev, ak, np, no;
            ev = model_evt();
            ak = (wr_en && idx == IDX_PEND && wdata[0]) ? 1 : 0;
            no = m_pend & m_en;
            np = (ev != 0 || (m_pend != 0 && ak == 0)) ? 1 : 0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(irq_in);
            if (wr_en && idx == IDX_CTRL) m_mode = int'(wdata[1:0]);
            if (wr_en && idx == IDX_EN)   m_en = int'(wdata[0]);
            m_pend = np; m_out = no;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL [%s] %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R7 irq_out layout0", 32'(out_a), 32'(m_out));
            chk("R7 irq_out layout1", 32'(out_b), 32'(m_out));
            chk("R9/R10 rdata layout0", rdata_a, model_rd());
            chk("R9/R10 rdata layout1", rdata_b, model_rd());
        end
    end

    task automatic step(logic irq, logic wr, int i, logic [31:0] d);
        @(negedge clk);
        #1;
        irq_in = irq; wr_en = wr; idx = i; wdata = d;
    endtask

    task automatic idle(logic irq, int i, int n);
        for (int k = 0; k < n; k++) step(irq, 1'b0, i, 32'd0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL [%s] watchdog expired actual=running expected=finished", phase);
        finish_run();
    end

    initial begin
        phase = "R8 reset";
        idle(1'b1, IDX_CTRL, 2);
        idle(1'b1, IDX_EN, 1);
        rst_n = 1'b1;
        idle(1'b1, IDX_PEND, 4);
        phase = "R7 enable and R5 ack";
        step(1'b1, 1'b1, IDX_EN, 32'h1);
        idle(1'b1, IDX_PEND, 2);
        step(1'b1, 1'b1, IDX_PEND, 32'hFFFF_FFFF);
        idle(1'b1, IDX_PEND, 3);
        phase = "R4 low level re-raise";
        idle(1'b0, IDX_PEND, 4);
        step(1'b0, 1'b1, IDX_PEND, 32'h1);
        idle(1'b0, IDX_PEND, 2);
        idle(1'b1, IDX_PEND, 3);
        step(1'b1, 1'b1, IDX_PEND, 32'h1);
        idle(1'b1, IDX_PEND, 2);
        phase = "R5 zero write ignored";
        idle(1'b0, IDX_PEND, 4);
        idle(1'b1, IDX_PEND, 3);
        step(1'b1, 1'b1, IDX_PEND, 32'hFFFF_FFFE);
        idle(1'b1, IDX_PEND, 2);
        step(1'b1, 1'b1, IDX_PEND, 32'h1);
        phase = "R1 high level mode";
        step(1'b0, 1'b1, IDX_CTRL, 32'hFFFF_FFFE);
        idle(1'b0, IDX_CTRL, 2);
        idle(1'b1, IDX_PEND, 4);
        step(1'b0, 1'b1, IDX_PEND, 32'h1);
        idle(1'b0, IDX_PEND, 4);
        phase = "R3 rising edge";
        step(1'b0, 1'b1, IDX_CTRL, 32'h3);
        step(1'b0, 1'b1, IDX_PEND, 32'h1);
        idle(1'b0, IDX_PEND, 3);
        idle(1'b1, IDX_PEND, 4);
        idle(1'b0, IDX_PEND, 3);
        step(1'b0, 1'b1, IDX_PEND, 32'h1);
        idle(1'b0, IDX_PEND, 3);
        phase = "R2 one-cycle pulse";
        step(1'b1, 1'b0, IDX_PEND, 32'h0);
        idle(1'b0, IDX_PEND, 4);
        step(1'b0, 1'b1, IDX_PEND, 32'h1);
        phase = "R3 falling edge";
        step(1'b1, 1'b1, IDX_CTRL, 32'h1);
        idle(1'b1, IDX_PEND, 3);
        step(1'b1, 1'b1, IDX_PEND, 32'h1);
        idle(1'b0, IDX_PEND, 4);
        phase = "R6 ack meets event";
        step(1'b1, 1'b1, IDX_CTRL, 32'h3);
        step(1'b1, 1'b1, IDX_PEND, 32'h1);
        step(1'b0, 1'b1, IDX_PEND, 32'h1);
        idle(1'b0, IDX_PEND, 3);
        step(1'b1, 1'b1, IDX_PEND, 32'h1);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, IDX_PEND, 32'h1);
        idle(1'b1, IDX_PEND, 2);
        phase = "R7 disable gate";
        step(1'b0, 1'b1, IDX_EN, 32'h0);
        idle(1'b0, IDX_PEND, 3);
        step(1'b0, 1'b1, IDX_EN, 32'h1);
        idle(1'b0, IDX_EN, 3);
        phase = "R9 unmapped address";
        step(1'b0, 1'b1, IDX_NONE, 32'hFFFF_FFFF);
        idle(1'b0, IDX_NONE, 1);
        idle(1'b0, IDX_CTRL, 1);
        idle(1'b0, IDX_EN, 1);
        idle(1'b0, IDX_PEND, 1);
        phase = "R2 random";
        for (int k = 0; k < 400; k++)
            step(1'($urandom), ($urandom % 4) == 0, int'($urandom % 4), $urandom);
        idle(1'b0, IDX_PEND, 3);
        finish_run();
    end
endmodule